// File: doc/BRIEF.md
# Configuration Access Port Decoder

This block is the host-side front end of the classic two-port configuration access scheme. A 32-bit address register is written and read through one I/O port. A four-byte data window at a second port turns each host access into one configuration read or write toward the devices on a single bus. The request carries device, function, dword register index, byte enables and lane-aligned write data. The target answers in the same cycle with a hit flag and read data.

Each host strobe is answered one cycle later with an acknowledge, a claimed flag and read data. An access that cannot be served is still acknowledged. Failed reads return all-ones sized to the access width, with zeros above it. A failed write has no side effect. Accesses to ports the block does not own are acknowledged as unclaimed. This lets the host's I/O fabric pass them on.

Top module: `cfgport_decoder`

## Requirements
- R1: A 4-byte write (size code 2 or 3) to port 0xCF8 stores all 32 bits in the address register, and a 4-byte read of 0xCF8 returns the stored value as claimed.
- R2: A 1- or 2-byte access to port 0xCF8 is acknowledged as unclaimed and leaves the address register unchanged; a narrow read returns 0xFF (size code 0) or 0xFFFF (size code 1).
- R3: Every host strobe is acknowledged exactly one cycle later; no acknowledge appears without a strobe. Size code 0 is 1 byte, 1 is 2 bytes, 2 and 3 are both 4 bytes.
- R4: While address bit 31 (enable) is clear, data-window accesses (ports 0xCFC to 0xCFF) are unclaimed, issue no downstream request, and reads return sized all-ones.
- R5: With enable set but address bits 1:0 not both zero, data-window accesses are claimed, issue no request, and reads return sized all-ones.
- R6: A nonzero bus field (address bits 23:16) makes data-window accesses fail the same way as R5.
- R7: The slot index {device, function} must be below 64 (device below 8); otherwise the access fails as in R5 with no request.
- R8: A served access raises cfg_req in the strobe cycle with device = bits 15:11, function = bits 10:8, register = bits 7:2, cfg_we equal to the host direction, and byte enables equal to the access's byte mask shifted left by port bits 1:0. Write data is moved up by 8 times that offset.
- R9: A served read returns the target's enabled bytes moved down to bit 0 with zeros above the access width when cfg_hit is high, and sized all-ones when cfg_hit is low.
- R10: A data-window access whose byte offset plus size exceeds 4 fails as in R5 with no request.
- R11: A failed data-window write issues no request, leaves the address register unchanged and is acknowledged after one cycle.
- R12: Accesses to any other port are unclaimed, issue no request and read as sized all-ones.
- R13: After reset the address register is zero and no acknowledge is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_req | input | 1 | Host access strobe, one cycle per access |
| io_we | input | 1 | Host direction, 1 = write |
| io_port | input | 16 | Host I/O port number |
| io_size | input | 2 | Access width code: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| io_wdata | input | 32 | Host write data, right-aligned |
| io_ack | output | 1 | Access completed (one cycle after io_req) |
| io_claimed | output | 1 | Port owned and access accepted |
| io_rdata | output | 32 | Read data, right-aligned, valid with io_ack |
| cfg_req | output | 1 | Downstream configuration request |
| cfg_we | output | 1 | Downstream direction, 1 = write |
| cfg_dev | output | 5 | Target device number |
| cfg_fn | output | 3 | Target function number |
| cfg_reg | output | 6 | Dword register index |
| cfg_be | output | 4 | Byte lane enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_hit | input | 1 | Target present and responding (same cycle) |
| cfg_rdata | input | 32 | Target read data dword (same cycle) |

## Verification
The bench targets the failure ordering: enable clear must yield an unclaimed result, while low-bit, bus, slot and lane-crossing faults must yield claimed all-ones. A design that swapped these would misreport ownership to the host fabric. It walks every byte offset and width, so an alignment error shows as wrong enables or shifted read data, and a missing crossing check shows as a stray request at offset 3. It also probes narrow writes to the address port and failed data writes. A design that latched these would change the read-back address or raise a spurious downstream write.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  localparam int DW = 32;

  typedef struct packed {
    logic       en;
    logic [6:0] rsvd;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] reg_idx;
    logic [1:0] low;
  } cfg_addr_t;

  // byte mask for a size code: 0 -> 1 byte, 1 -> 2 bytes, 2/3 -> 4 bytes
  function automatic logic [3:0] size_mask(logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = 4'b0001;
      2'd1:    size_mask = 4'b0011;
      default: size_mask = 4'b1111;
    endcase
  endfunction

  function automatic logic [DW-1:0] ones_for(logic [1:0] sz);
    case (sz)
      2'd0:    ones_for = 32'h0000_00FF;
      2'd1:    ones_for = 32'h0000_FFFF;
      default: ones_for = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/cfgport_addr_reg.sv
module cfgport_addr_reg
  import cfgport_pkg::*;
#(
  parameter int                PORT_W    = 16,
  parameter logic [PORT_W-1:0] ADDR_PORT = 16'hCF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_req,
  input  logic              io_we,
  input  logic [PORT_W-1:0] io_port,
  input  logic [1:0]        io_size,
  input  logic [DW-1:0]     io_wdata,
  output cfg_addr_t         addr_q,
  output logic              port_hit,
  output logic              full_width
);

  cfg_addr_t addr_d;
  logic      load_en;

  assign port_hit   = (io_port == ADDR_PORT);
  assign full_width = io_size[1];
  assign load_en    = io_req && io_we && port_hit && full_width;

  always_comb begin
    addr_d = addr_q;
    if (load_en) addr_d = cfg_addr_t'(io_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_req && io_we && (io_port == ADDR_PORT) && io_size[1]) |=> $stable(addr_q)); // R2

endmodule

// File: rtl/cfgport_lane_map.sv
module cfgport_lane_map
  import cfgport_pkg::*;
(
  input  logic [1:0]    offset,
  input  logic [1:0]    io_size,
  input  logic [DW-1:0] wdata_in,
  input  logic [DW-1:0] rdata_in,
  output logic [3:0]    be,
  output logic          crosses,
  output logic [DW-1:0] wdata_lane,
  output logic [DW-1:0] rdata_align
);

  logic [7:0] spread;

  always_comb begin
    spread      = {4'b0000, size_mask(io_size)} << offset;
    be          = spread[3:0];
    crosses     = |spread[7:4];
    wdata_lane  = wdata_in << {offset, 3'b000};
    rdata_align = (rdata_in >> {offset, 3'b000}) & ones_for(io_size);
  end

endmodule

// File: rtl/cfgport_resp.sv
module cfgport_resp
  import cfgport_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_req,
  input  logic          claimed_d,
  input  logic [DW-1:0] rdata_d,
  output logic          io_ack,
  output logic          io_claimed,
  output logic [DW-1:0] io_rdata
);

  logic          ack_n;
  logic          claimed_n;
  logic [DW-1:0] rdata_n;

  always_comb begin
    ack_n     = io_req;
    claimed_n = io_claimed;
    rdata_n   = io_rdata;
    if (io_req) begin
      claimed_n = claimed_d;
      rdata_n   = rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_ack     <= 1'b0;
      io_claimed <= 1'b0;
      io_rdata   <= '0;
    end else begin
      io_ack     <= ack_n;
      io_claimed <= claimed_n;
      io_rdata   <= rdata_n;
    end
  end

  AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    io_req |=> io_ack); // R3
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !io_req |=> !io_ack); // R3

endmodule

// File: rtl/cfgport_decoder.sv
module cfgport_decoder
  import cfgport_pkg::*;
#(
  parameter int                PORT_W     = 16,
  parameter logic [PORT_W-1:0] ADDR_PORT  = 16'hCF8,
  parameter logic [PORT_W-1:0] DATA_PORT  = 16'hCFC,
  parameter int                SLOT_COUNT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_req,
  input  logic              io_we,
  input  logic [PORT_W-1:0] io_port,
  input  logic [1:0]        io_size,
  input  logic [DW-1:0]     io_wdata,
  output logic              io_ack,
  output logic              io_claimed,
  output logic [DW-1:0]     io_rdata,
  output logic              cfg_req,
  output logic              cfg_we,
  output logic [4:0]        cfg_dev,
  output logic [2:0]        cfg_fn,
  output logic [5:0]        cfg_reg,
  output logic [3:0]        cfg_be,
  output logic [DW-1:0]     cfg_wdata,
  input  logic              cfg_hit,
  input  logic [DW-1:0]     cfg_rdata
);

  localparam int SLOT_IDX_W = 8;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  cfg_addr_t addr_q;
  logic      addr_port_hit;
  logic      addr_full;

  cfgport_addr_reg #(
    .PORT_W    (PORT_W),
    .ADDR_PORT (ADDR_PORT)
  ) u_addr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .io_req     (io_req),
    .io_we      (io_we),
    .io_port    (io_port),
    .io_size    (io_size),
    .io_wdata   (io_wdata),
    .addr_q     (addr_q),
    .port_hit   (addr_port_hit),
    .full_width (addr_full)
  );

  logic          crosses;
  logic [DW-1:0] rdata_align;

  cfgport_lane_map u_lanes (
    .offset      (io_port[1:0]),
    .io_size     (io_size),
    .wdata_in    (io_wdata),
    .rdata_in    (cfg_rdata),
    .be          (cfg_be),
    .crosses     (crosses),
    .wdata_lane  (cfg_wdata),
    .rdata_align (rdata_align)
  );

  logic                  data_port_hit;
  logic [SLOT_IDX_W-1:0] slot_idx;
  logic                  slot_ok;
  logic                  path_ok;
  logic                  claimed_d;
  logic [DW-1:0]         rdata_d;

  assign data_port_hit = (io_port[PORT_W-1:2] == DATA_PORT[PORT_W-1:2]);
  assign slot_idx      = {addr_q.dev, addr_q.fn};
  assign slot_ok       = (int'(slot_idx) < SLOT_COUNT);
  assign path_ok       = addr_q.en && (addr_q.low == 2'b00) &&
                         (addr_q.bus == 8'h00) && slot_ok && !crosses;

  assign cfg_req = io_req && data_port_hit && path_ok;
  assign cfg_we  = io_we;
  assign cfg_dev = addr_q.dev;
  assign cfg_fn  = addr_q.fn;
  assign cfg_reg = addr_q.reg_idx;

  always_comb begin
    claimed_d = 1'b0;
    rdata_d   = ones_for(io_size);
    if (addr_port_hit) begin
      claimed_d = addr_full;
      if (addr_full) rdata_d = DW'(addr_q);
    end else if (data_port_hit) begin
      claimed_d = addr_q.en;
      if (path_ok && cfg_hit) rdata_d = rdata_align;
    end
  end

  cfgport_resp u_resp (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .io_req     (io_req),
    .claimed_d  (claimed_d),
    .rdata_d    (rdata_d),
    .io_ack     (io_ack),
    .io_claimed (io_claimed),
    .io_rdata   (io_rdata)
  );

  AST_UNCLAIMED_ONES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_req && !io_we && !data_port_hit && !(addr_port_hit && addr_full))
      |=> (!io_claimed && io_rdata == ones_for($past(io_size)))); // R12
  AST_DISABLED_NO_REQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_req |-> (addr_q.en && addr_q.bus == 8'h00)); // R4
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_req |-> (int'({cfg_dev, cfg_fn}) < SLOT_COUNT)); // R7
  AST_BE_MATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_req |-> ($countones(cfg_be) == $countones(size_mask(io_size)))); // R10

endmodule

// File: tb/cfgport_decoder_bench.sv
module cfgport_decoder_bench;

  logic        clk;
  logic        rst_n;
  logic        io_req, io_we;
  logic [15:0] io_port;
  logic [1:0]  io_size;
  logic [31:0] io_wdata;
  logic        io_ack, io_claimed;
  logic [31:0] io_rdata;
  logic        cfg_req, cfg_we;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_fn;
  logic [5:0]  cfg_reg;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cfg_hit;
  logic [31:0] cfg_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] m_addr;
  logic        m_ack;

  cfgport_decoder u_cfgport_decoder (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_we(io_we), .io_port(io_port),
    .io_size(io_size), .io_wdata(io_wdata), .io_ack(io_ack), .io_claimed(io_claimed),
    .io_rdata(io_rdata), .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_dev(cfg_dev),
    .cfg_fn(cfg_fn), .cfg_reg(cfg_reg), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_hit(cfg_hit), .cfg_rdata(cfg_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural target: some slots absent, data derived from slot and register
  function automatic bit present(int slot);
    return (slot % 5) != 3;
  endfunction
  function automatic logic [31:0] tgt_data(int slot, int rg);
    return {8'(rg ^ 8'hC3), 8'(slot), 8'(rg * 3 + 1), 8'h5A};
  endfunction

  always_comb begin
    cfg_hit   = cfg_req && present(int'({cfg_dev, cfg_fn}));
    cfg_rdata = tgt_data(int'({cfg_dev, cfg_fn}), int'(cfg_reg));
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // acknowledge model, compared on every clock
  always @(posedge clk) m_ack <= rst_n ? io_req : 1'b0;
  always @(negedge clk) if (rst_n) chk("R3 ack", {31'b0, io_ack}, {31'b0, m_ack});

  task automatic access(string tag, bit we, int port, int sz, logic [31:0] wd);
    int nb, off, slot;
    bit own_a, own_d, fail, exp_req, exp_claim;
    logic [31:0] ones, exp_rd;
    nb   = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    ones = (nb == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * nb)) - 1);
    off  = port & 3;
    slot = int'(m_addr[15:8]);
    own_a = (port == 'hCF8);
    own_d = (port >= 'hCFC && port <= 'hCFF);
    fail  = !m_addr[31] || m_addr[1:0] != 0 || m_addr[23:16] != 0 || slot >= 64 || off + nb > 4;
    exp_req = own_d && !fail;
    exp_claim = own_a ? (nb == 4) : own_d ? m_addr[31] : 1'b0;
    exp_rd = ones;
    if (own_a && nb == 4) exp_rd = m_addr;
    if (exp_req && present(slot))
      exp_rd = (tgt_data(slot, int'(m_addr[7:2])) >> (8 * off)) & ones;
    @(negedge clk);
    io_req = 1'b1; io_we = we; io_port = 16'(port); io_size = 2'(sz); io_wdata = wd;
    #1;
    chk({tag, " req"}, {31'b0, cfg_req}, {31'b0, exp_req});
    if (exp_req) begin
      chk({tag, " be"}, {28'b0, cfg_be}, 32'(((1 << nb) - 1) << off));
      chk({tag, " sel"}, {18'b0, cfg_dev, cfg_fn, cfg_reg}, {18'b0, m_addr[15:2]});
      chk({tag, " we"}, {31'b0, cfg_we}, {31'b0, we});
      if (we) chk({tag, " wdata"}, cfg_wdata, wd << (8 * off));
    end
    @(posedge clk); #1;
    io_req = 1'b0;
    chk({tag, " claim"}, {31'b0, io_claimed}, {31'b0, exp_claim});
    if (!we) chk({tag, " rdata"}, io_rdata, exp_rd);
    if (we && own_a && nb == 4) m_addr = wd;
  endtask

  initial begin
    io_req = 0; io_we = 0; io_port = 0; io_size = 0; io_wdata = 0;
    m_addr = 32'h0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R13 ack idle", {31'b0, io_ack}, 32'h0);
    access("R13 addr reset", 0, 'hCF8, 2, 0);
    access("R1 write", 1, 'hCF8, 2, 32'h8000_1234 & 32'hFFFF_FFFC);
    access("R1 readback", 0, 'hCF8, 2, 0);
    access("R3 size3 write", 1, 'hCF8, 3, 32'h0000_0A14);
    access("R3 size3 read", 0, 'hCF8, 3, 0);
    access("R2 narrow write", 1, 'hCF8, 0, 32'hFFFF_FFFF);
    access("R2 half write", 1, 'hCF8, 1, 32'h8000_0000);
    access("R2 after narrow", 0, 'hCF8, 2, 0);
    access("R2 narrow read", 0, 'hCF8, 0, 0);
    access("R2 half read", 0, 'hCF8, 1, 0);
    access("R4 disabled read", 0, 'hCFC, 2, 0);
    access("R4 disabled write", 1, 'hCFE, 1, 32'h1234);
    // enabled: dev 2 fn 1 reg 5 -> slot 17 present
    access("R1 set", 1, 'hCF8, 2, 32'h8000_1114);
    for (int o = 0; o < 4; o++) access("R9 byte", 0, 'hCFC + o, 0, 0);
    access("R9 half lo", 0, 'hCFC, 1, 0);
    access("R9 half hi", 0, 'hCFE, 1, 0);
    access("R9 half mid", 0, 'hCFD, 1, 0);
    access("R9 word", 0, 'hCFC, 2, 0);
    access("R8 word write", 1, 'hCFC, 2, 32'hDEAD_BEEF);
    access("R8 byte write", 1, 'hCFF, 0, 32'h0000_00A7);
    access("R8 half write", 1, 'hCFE, 1, 32'h0000_55AA);
    access("R10 half cross", 0, 'hCFF, 1, 0);
    access("R10 word cross", 0, 'hCFD, 2, 0);
    access("R11 cross write", 1, 'hCFF, 1, 32'hFFFF);
    access("R11 addr kept", 0, 'hCF8, 2, 0);
    // absent slot: dev 2 fn 5 -> slot 21, 21 % 5 == 1 present; use slot 18 (dev2 fn2)
    access("R1 set miss", 1, 'hCF8, 2, 32'h8000_1208);
    access("R9 miss read", 0, 'hCFC, 2, 0);
    access("R9 miss byte", 0, 'hCFD, 0, 0);
    access("R5 set low", 1, 'hCF8, 2, 32'h8000_1101);
    access("R5 low read", 0, 'hCFC, 1, 0);
    access("R5 low write", 1, 'hCFC, 2, 32'h1);
    access("R6 set bus", 1, 'hCF8, 2, 32'h8001_1100);
    access("R6 bus read", 0, 'hCFC, 2, 0);
    access("R7 set dev9", 1, 'hCF8, 2, 32'h8000_4800);
    access("R7 dev9 read", 0, 'hCFC, 2, 0);
    access("R7 dev9 write", 1, 'hCFC, 2, 32'h77);
    access("R7 set dev7", 1, 'hCF8, 2, 32'h8000_3F00);
    access("R7 dev7 read", 0, 'hCFC, 2, 0);
    access("R12 port cf9", 0, 'hCF9, 2, 0);
    access("R12 port cfb", 0, 'hCFB, 0, 0);
    access("R12 port 80", 1, 'h0080, 2, 32'h5);
    access("R12 port d00", 0, 'hD00, 1, 0);
    access("R11 final addr", 0, 'hCF8, 2, 0);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule